// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block turns a bank of PCI-rate output clocks on and off without glitches. It is used in a clock generator where a platform can pause the bus clocks while the rest of the chip keeps running. A stop can come from two places: an asynchronous active-low pin, and an active-low run bit held in a configuration register. If either source asks for a stop, the seven stoppable outputs are parked low. All seven stop on the same source edge and restart on the same source edge. A readback bit shows whether the stoppable clocks are running.

Three further outputs can be made free-running, one control bit each. With its bit set, a free-runnable output ignores every stop request. With its bit clear, it behaves like a stoppable output. The pin passes through a two-flop synchronizer. A two-state controller, clocked on the falling source edge, decides whether the bank runs. Its state names are HALT and RUN. The transition STOP goes from RUN to HALT when the combined run request is low, and the transition START goes from HALT to RUN when the request is high. The per-output enable flops also load on the falling edge. Every enable therefore changes only while the source clock is low, and each output is the source clock ANDed with its enable.

Top module: `pci_stop_gate`

## Requirements
- R1: When `stop_pin_n` falls and is captured at source rising edge k, the stoppable outputs still give full pulses at edges k and k+1 and are low from edge k+2 onward.
- R2: The bank runs only when both the synchronized pin and the registered `reg_run_bit` are 1. A 0 on `reg_run_bit` captured at edge k gates the outputs from edge k+1, and a 1 captured at edge k restarts them at edge k+1 if the pin is high. Raising only one of the two sources while the other is low leaves the bank stopped.
- R3: In HALT, every stoppable output is held at logic 0 through both clock phases.
- R4: All seven bits of `clk_stop_out` are always equal, so they stop and resume on the same edge.
- R5: Bit i of `free_sel` exempts `clk_free_out[i]` from stopping. A change of `free_sel` captured at edge k takes effect at edge k+1. A free output whose bit is 0 follows the stoppable bank.
- R6: When `stop_pin_n` rises and is captured at edge k, the stoppable outputs pulse again from edge k+2, which is within two source periods.
- R7: `run_status` is 0 whenever the synchronized pin or the registered run bit is 0, and 1 otherwise. It falls one edge after a pin capture, and at the capturing edge itself for the register bit.
- R8: Enables change only while the source clock is low, so no output is ever high during the low phase, and no high pulse is cut short.
- R9: While `rst_n` is low, all outputs and `run_status` are 0. After release with the pin high, the bank first pulses at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | PCI-rate source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Asynchronous active-low stop pin |
| reg_run_bit | input | 1 | Register run bit, 0 requests a stop |
| free_sel | input | 3 | Per-output free-run select for the free-runnable outputs |
| clk_stop_out | output | 7 | Gated stoppable clocks |
| clk_free_out | output | 3 | Gated free-runnable clocks |
| run_status | output | 1 | 1 when the stoppable clocks are allowed to run |

## Verification
The hardest cases to reach are the half-cycle windows: a request that lands between a rising edge and the following falling edge, where the enable must move in the low phase and leave the current high pulse whole. The bench drives every input 1.5 ns after a rising edge. It checks the outputs in the high phase of each following cycle, so the exact edge of every change is fixed. It also checks again just before the falling edge, and in the low phase of many cycles, while the register bit, the pin and the free-run selects change at that point. Holding both sources low and then releasing them one at a time exercises the AND combination and the START transition.

// File: rtl/stop_gate_pkg.sv
`timescale 1ns/1ps
package stop_gate_pkg;
    // Controller state: bank parked low, or bank passing the source clock.
    typedef enum logic {
        GS_HALT = 1'b0,
        GS_RUN  = 1'b1
    } gate_state_t;
endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // The chain resets to 0, so the bank starts in the stopped state.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/stop_fsm.sv
`timescale 1ns/1ps
module stop_fsm
    import stop_gate_pkg::*;
#(
    parameter int N_STOP = 7,
    parameter int N_FREE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic [N_FREE-1:0] free_sel,
    output logic [N_STOP-1:0] en_stop,
    output logic [N_FREE-1:0] en_free,
    output logic [N_FREE-1:0] free_q,
    output logic              in_run
);
    gate_state_t state, nxt;

    // Next state: STOP (RUN->HALT) and START (HALT->RUN).
    always_comb begin
        nxt = state;
        unique case (state)
            GS_HALT: if (run_req)  nxt = GS_RUN;
            GS_RUN:  if (!run_req) nxt = GS_HALT;
            default: nxt = GS_HALT;
        endcase
    end

    // The state register loads on the falling source edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_HALT;
        else        state <= nxt;
    end

    // Output enables also load on the falling edge, decoded from the next state.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_stop <= '0;
            en_free <= '0;
            free_q  <= '0;
        end else begin
            en_stop <= {N_STOP{nxt == GS_RUN}};
            en_free <= free_sel | {N_FREE{nxt == GS_RUN}};
            free_q  <= free_sel;
        end
    end

    assign in_run = (state == GS_RUN);
endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
    input  logic clk_src,
    input  logic en,
    output logic clk_g
);
    // en moves only while clk_src is low, so the AND cannot make a runt pulse.
    assign clk_g = clk_src & en;
endmodule

// File: rtl/pci_stop_gate.sv
`timescale 1ns/1ps
module pci_stop_gate #(
    parameter int N_STOP      = 7,
    parameter int N_FREE      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              stop_pin_n,
    input  logic              reg_run_bit,
    input  logic [N_FREE-1:0] free_sel,
    output logic [N_STOP-1:0] clk_stop_out,
    output logic [N_FREE-1:0] clk_free_out,
    output logic              run_status
);
    logic              pin_run;
    logic              reg_q;
    logic              run_req;
    logic [N_STOP-1:0] en_stop;
    logic [N_FREE-1:0] en_free;
    logic [N_FREE-1:0] free_q;
    logic              fsm_run;

    stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .async_in (stop_pin_n),
        .sync_out (pin_run)
    );

    // The register run bit comes from the same clock domain: a single capture flop.
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) reg_q <= 1'b1;
        else        reg_q <= reg_run_bit;
    end

    // R2: run only when both sources agree. R7: readback shows the combined request.
    assign run_req    = pin_run & reg_q;
    assign run_status = run_req;

    stop_fsm #(.N_STOP(N_STOP), .N_FREE(N_FREE)) u_fsm (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .free_sel (free_sel),
        .en_stop  (en_stop),
        .en_free  (en_free),
        .free_q   (free_q),
        .in_run   (fsm_run)
    );

    genvar s;
    generate
        for (s = 0; s < N_STOP; s++) begin : g_stop
            clk_gate_cell u_cell (
                .clk_src (clk_src),
                .en      (en_stop[s]),
                .clk_g   (clk_stop_out[s])
            );
        end
        for (s = 0; s < N_FREE; s++) begin : g_free
            clk_gate_cell u_cell (
                .clk_src (clk_src),
                .en      (en_free[s]),
                .clk_g   (clk_free_out[s])
            );
        end
    endgenerate
endmodule

// File: rtl/stop_gate_chk.sv
`timescale 1ns/1ps
module stop_gate_chk #(
    parameter int N_STOP = 7,
    parameter int N_FREE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_run,
    input  logic [N_STOP-1:0] en_stop,
    input  logic [N_FREE-1:0] en_free,
    input  logic [N_FREE-1:0] free_q
);
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stop == '0) || (en_stop == '1));

    a_r3_halt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !in_run |-> (en_stop == '0));

    a_r5_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q & ~en_free) == '0);

    a_r5_run_superset: assert property (@(posedge clk) disable iff (!rst_n)
        en_stop[0] |-> (en_free == '1));
endmodule

bind pci_stop_gate stop_gate_chk #(.N_STOP(N_STOP), .N_FREE(N_FREE)) u_chk (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .in_run  (fsm_run),
    .en_stop (en_stop),
    .en_free (en_free),
    .free_q  (free_q)
);

// File: tb/sim_pci_stop_gate.sv
`timescale 1ns/100ps
module sim_pci_stop_gate;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       stop_pin_n;
    logic       reg_run_bit;
    logic [2:0] free_sel;
    logic [6:0] clk_stop_out;
    logic [2:0] clk_free_out;
    logic       run_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pci_stop_gate u0 (
        .clk_src      (clk),
        .rst_n        (rst_n),
        .stop_pin_n   (stop_pin_n),
        .reg_run_bit  (reg_run_bit),
        .free_sel     (free_sel),
        .clk_stop_out (clk_stop_out),
        .clk_free_out (clk_free_out),
        .run_status   (run_status)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // Check point: 1.5 ns after a rising edge, in the high phase.
    task automatic tick();
        @(posedge clk);
        #1.5;
    endtask

    task automatic expect_out(input bit run, input logic [2:0] fr, input string tag);
        chk(clk_stop_out == {7{run}}, tag, {9'd0, clk_stop_out}, {9'd0, {7{run}}});
        chk(clk_free_out == fr, tag, {13'd0, clk_free_out}, {13'd0, fr});
    endtask

    task automatic expect_status(input bit v, input string tag);
        chk(run_status == v, tag, {15'd0, run_status}, {15'd0, v});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stop_pin_n = 1'b1; reg_run_bit = 1'b1; free_sel = 3'b000;
        repeat (3) tick();
        expect_out(1'b0, 3'b000, "R9 outputs low in reset");
        expect_status(1'b0, "R9 status low in reset");
        rst_n = 1'b1;                       // released at point j
        tick(); expect_out(1'b0, 3'b000, "R9 j+1 still stopped");
        tick(); expect_out(1'b0, 3'b000, "R9 j+2 still stopped");
        expect_status(1'b1, "R9 status after sync");
        tick(); expect_out(1'b1, 3'b111, "R9 first pulse at j+3");
    endtask

    task automatic t_pin_stop_resume();
        stop_pin_n = 1'b0;                  // point j
        tick(); expect_out(1'b1, 3'b111, "R1 j+1 pulse kept");
        expect_status(1'b1, "R7 status before sync");
        tick(); expect_out(1'b1, 3'b111, "R1 j+2 pulse kept");
        expect_status(1'b0, "R7 status falls");
        tick(); expect_out(1'b0, 3'b000, "R1 j+3 stopped R4 aligned");
        #2.0; expect_out(1'b0, 3'b000, "R3 held low in low phase");
        tick(); expect_out(1'b0, 3'b000, "R3 held low high phase");
        stop_pin_n = 1'b1;                  // point j'
        tick(); expect_out(1'b0, 3'b000, "R6 j'+1 still stopped");
        tick(); expect_out(1'b0, 3'b000, "R6 j'+2 still stopped");
        expect_status(1'b1, "R7 status rises");
        tick(); expect_out(1'b1, 3'b111, "R6 resumed within two periods");
    endtask

    task automatic t_reg_stop();
        reg_run_bit = 1'b0;                 // point j
        tick(); expect_status(1'b0, "R7 status follows register bit");
        expect_out(1'b1, 3'b111, "R2 j+1 pulse kept");
        tick(); expect_out(1'b0, 3'b000, "R2 register bit stops bank");
        reg_run_bit = 1'b1;
        tick(); expect_out(1'b0, 3'b000, "R2 j+1 after release");
        expect_status(1'b1, "R7 status back");
        tick(); expect_out(1'b1, 3'b111, "R2 register bit restarts bank");
    endtask

    task automatic t_both_low();
        stop_pin_n = 1'b0; reg_run_bit = 1'b0;
        repeat (3) tick();
        expect_out(1'b0, 3'b000, "R2 both low stopped");
        reg_run_bit = 1'b1;
        repeat (3) tick();
        expect_out(1'b0, 3'b000, "R2 pin alone holds stop");
        expect_status(1'b0, "R7 pin alone low status");
        stop_pin_n = 1'b1;
        tick(); tick();
        expect_out(1'b0, 3'b000, "R2 pin rising j+2");
        tick();
        expect_out(1'b1, 3'b111, "R2 both high run");
    endtask

    task automatic t_free();
        reg_run_bit = 1'b0;
        tick(); tick();
        expect_out(1'b0, 3'b000, "R5 all stopped with selects clear");
        free_sel = 3'b101;
        tick(); expect_out(1'b0, 3'b101, "R5 select 101 exempts bits 0 and 2");
        free_sel = 3'b010;
        tick(); expect_out(1'b0, 3'b010, "R5 select 010 exempts bit 1");
        reg_run_bit = 1'b1;
        tick(); expect_out(1'b0, 3'b010, "R5 free bit 1 while bank waits");
        tick(); expect_out(1'b1, 3'b111, "R5 all free outputs run with bank");
        free_sel = 3'b000;
        tick(); expect_out(1'b1, 3'b111, "R5 cleared select while running");
    endtask

    task automatic t_low_phase();
        free_sel = 3'b100;
        for (int i = 0; i < 24; i++) begin
            if (i % 4 == 0) reg_run_bit = ~reg_run_bit;
            if (i % 7 == 3) stop_pin_n = ~stop_pin_n;
            #2.0;   // 3.5 ns after the edge: low phase
            chk(clk_stop_out == 7'd0 && clk_free_out == 3'd0, "R8 low phase quiet",
                {6'd0, clk_stop_out, clk_free_out}, 16'd0);
            tick();
        end
        // Bring the bank back to running, then stop it and check that the high pulse stays whole.
        stop_pin_n = 1'b1; reg_run_bit = 1'b1;
        repeat (4) tick();
        reg_run_bit = 1'b0;
        tick();
        #0.7;   // 2.2 ns: late in the high phase of the last kept pulse
        chk(clk_stop_out == 7'h7f, "R8 last pulse not cut short",
            {9'd0, clk_stop_out}, 16'h007f);
        tick(); expect_out(1'b0, 3'b100, "R8 gated after whole pulse");
        reg_run_bit = 1'b1; free_sel = 3'b000;
        repeat (3) tick();
    endtask

    initial begin
        t_reset();
        t_pin_stop_resume();
        t_reg_stop();
        t_both_low();
        t_free();
        t_low_phase();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule